// File: doc/BRIEF.md
# Bit-Manipulation ALU Extension

This combinational unit sits beside the main adder/logic path of a 32-bit integer core. It handles the operations that an ordinary adder does not. These are a single-bit test that rewrites condition flags, byte-local bit reversal, byte and halfword swaps, one iteration of a restoring divide, an unsigned clamp, a leading-zero count, shifts by a register-held amount, and a signed or unsigned multiply whose upper word comes out on a separate port. Two operands, A and B, come in together with the current status word. A 4-bit opcode picks the operation. The unit returns a result, an updated status word and the multiply upper word in the same cycle.

The design has two parts under a thin top. A decoder turns the opcode into a bundle of one-hot strobes. A datapath computes every candidate and selects one under those strobes. Status bits follow a fixed layout: bit 4 is X (extend), bit 3 is N (negative) and bit 2 is Z (zero). Only the bit-test operation changes the status word; every other opcode passes it through.

Top module: `bmx_unit`

## Requirements
- R1: Opcode 0 (bit test) selects bit B[4:0] of A. It returns A unchanged as the result, and status bit 3 (N) takes the value of the selected bit.
- R2: Under opcode 0, status bit 2 (Z) is 1 exactly when the selected bit of A and every bit of A below it are 0. Bits of B above bit 4 have no effect.
- R3: Opcode 0 clears status bit 4 (X) and leaves every status bit other than 4, 3 and 2 equal to the status input. All other opcodes return the status input unchanged.
- R4: Opcode 1 reverses the bit order within each of the four bytes of A, and no bit leaves its byte.
- R5: Opcode 2 exchanges the two bytes inside each 16-bit half of A. Opcode 3 exchanges the upper and lower 16-bit halves of A.
- R6: Opcode 4 (divide step) shifts A left by one, dropping bit 31 and inserting 0. It subtracts B when the shifted value is unsigned greater than or equal to B.
- R7: Opcode 5 (bound) returns B when A is unsigned greater than B, and A otherwise.
- R8: Opcode 6 returns the number of leading zero bits of B, which is 32 when B is 0.
- R9: Opcodes 7, 8 and 9 shift A left logically, right logically and right arithmetically, by B read as an unsigned 32-bit count. A count above 31 gives 0 for the logical shifts. For the arithmetic shift it gives all ones when A[31] is 1, and 0 otherwise.
- R10: Opcode 10 (signed) and opcode 11 (unsigned) multiply A by B. The result is the low 32 bits of the 64-bit product and the upper-word output is the high 32 bits. Every other opcode drives the upper-word output to 0.
- R11: Opcodes 12 to 15 return A unchanged, the status input unchanged and an upper word of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation code |
| aIn | input | 32 | Operand A (destination value) |
| bIn | input | 32 | Operand B (source value, bit number or shift count) |
| statusIn | input | 32 | Current status word |
| resultOut | output | 32 | Operation result |
| statusOut | output | 32 | Updated status word |
| mulHighOut | output | 32 | Upper 32 bits of the multiply product |

## Verification
Random operands rarely reach the bit-test Z flag's corner cases: the selected bit and all lower bits are zero while higher bits are set, the selected bit is 31, or B carries a bit number with junk above bit 4. Shifts with counts far above 31 combined with a negative A, and a divide step whose shifted value equals B exactly, are just as unlikely. The stimulus therefore starts with directed operand pairs built for those cases, running each pair through all sixteen opcodes under several status words. It then adds pseudo-random pairs whose B is sometimes masked to a small count. A behavioural model compares the result, status and upper word on every clock.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_BTST  = 4'd0,
    OP_BREV  = 4'd1,
    OP_BSWAP = 4'd2,
    OP_HSWAP = 4'd3,
    OP_DSTEP = 4'd4,
    OP_BOUND = 4'd5,
    OP_LZC   = 4'd6,
    OP_SHL   = 4'd7,
    OP_SHR   = 4'd8,
    OP_SAR   = 4'd9,
    OP_MULS  = 4'd10,
    OP_MULU  = 4'd11
  } bmx_op_e;

  typedef struct packed {
    logic doBtst;
    logic doBrev;
    logic doBswap;
    logic doHswap;
    logic doDstep;
    logic doBound;
    logic doLzc;
    logic doShl;
    logic doShr;
    logic doSar;
    logic doMul;
    logic mulSigned;
  } bmx_strobe_t;
endpackage

// File: rtl/bmx_ctrl.sv
module bmx_ctrl
  import bmx_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output bmx_strobe_t     strobes
);
  always_comb begin
    strobes = '0;
    case (opSel)
      OP_BTST:  strobes.doBtst  = 1'b1;
      OP_BREV:  strobes.doBrev  = 1'b1;
      OP_BSWAP: strobes.doBswap = 1'b1;
      OP_HSWAP: strobes.doHswap = 1'b1;
      OP_DSTEP: strobes.doDstep = 1'b1;
      OP_BOUND: strobes.doBound = 1'b1;
      OP_LZC:   strobes.doLzc   = 1'b1;
      OP_SHL:   strobes.doShl   = 1'b1;
      OP_SHR:   strobes.doShr   = 1'b1;
      OP_SAR:   strobes.doSar   = 1'b1;
      OP_MULS: begin
        strobes.doMul     = 1'b1;
        strobes.mulSigned = 1'b1;
      end
      OP_MULU:  strobes.doMul   = 1'b1;
      default:  strobes = '0;
    endcase
  end
endmodule

// File: rtl/bmx_datapath.sv
module bmx_datapath
  import bmx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAT_W = 32,
  parameter int XBIT   = 4,
  parameter int NBIT   = 3,
  parameter int ZBIT   = 2
) (
  input  bmx_strobe_t       strobes,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic [STAT_W-1:0] statusIn,
  output logic [DATA_W-1:0] resultOut,
  output logic [STAT_W-1:0] statusOut,
  output logic [DATA_W-1:0] mulHighOut
);
  localparam int SHW     = $clog2(DATA_W);
  localparam int CNT_W   = $clog2(DATA_W + 1);
  localparam int N_BYTES = DATA_W / 8;
  localparam int N_HALF  = DATA_W / 16;
  localparam int HALF_W  = DATA_W / 2;
  localparam logic [DATA_W-1:0] SH_MAX = DATA_W'(DATA_W - 1);
  localparam logic [STAT_W-1:0] FLAG_MASK =
    (STAT_W'(1) << XBIT) | (STAT_W'(1) << NBIT) | (STAT_W'(1) << ZBIT);

  // bit test
  logic [SHW-1:0]    bitSel;
  logic [DATA_W-1:0] lowMask;
  logic              btBit;
  logic              btZero;
  assign bitSel  = bIn[SHW-1:0];
  assign lowMask = {DATA_W{1'b1}} >> (SH_MAX[SHW-1:0] - bitSel);
  assign btBit   = aIn[bitSel];
  assign btZero  = ~|(aIn & lowMask);

  // per-byte reverse and byte swap
  logic [DATA_W-1:0] brevVal;
  logic [DATA_W-1:0] bswapVal;
  logic [DATA_W-1:0] hswapVal;
  for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
    for (genvar i = 0; i < 8; i++) begin : g_bit
      assign brevVal[8*k + i] = aIn[8*k + 7 - i];
    end
  end
  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    assign bswapVal[16*h +: 8]     = aIn[16*h + 8 +: 8];
    assign bswapVal[16*h + 8 +: 8] = aIn[16*h +: 8];
  end
  assign hswapVal = {aIn[HALF_W-1:0], aIn[DATA_W-1:HALF_W]};

  // divide step and bound
  logic [DATA_W-1:0] dsShift;
  logic [DATA_W-1:0] dstepVal;
  logic [DATA_W-1:0] boundVal;
  assign dsShift  = {aIn[DATA_W-2:0], 1'b0};
  assign dstepVal = (dsShift >= bIn) ? (dsShift - bIn) : dsShift;
  assign boundVal = (aIn > bIn) ? bIn : aIn;

  // leading zeros of B
  logic [CNT_W-1:0] lzCount;
  always_comb begin
    lzCount = CNT_W'(DATA_W);
    for (int i = 0; i < DATA_W; i++) begin
      if (bIn[i]) lzCount = CNT_W'(DATA_W - 1 - i);
    end
  end

  // shifts by register amount
  logic              shBig;
  logic [SHW-1:0]    shAmt;
  logic [DATA_W-1:0] shlVal;
  logic [DATA_W-1:0] shrVal;
  logic [DATA_W-1:0] sarVal;
  assign shBig  = bIn > SH_MAX;
  assign shAmt  = bIn[SHW-1:0];
  assign shlVal = shBig ? '0 : (aIn << shAmt);
  assign shrVal = shBig ? '0 : (aIn >> shAmt);
  assign sarVal = shBig ? {DATA_W{aIn[DATA_W-1]}} : DATA_W'($signed(aIn) >>> shAmt);

  // multiply
  logic [2*DATA_W-1:0] mulA;
  logic [2*DATA_W-1:0] mulB;
  logic [2*DATA_W-1:0] product;
  assign mulA    = {{DATA_W{strobes.mulSigned & aIn[DATA_W-1]}}, aIn};
  assign mulB    = {{DATA_W{strobes.mulSigned & bIn[DATA_W-1]}}, bIn};
  assign product = mulA * mulB;

  always_comb begin
    resultOut  = aIn;
    statusOut  = statusIn;
    mulHighOut = '0;
    if (strobes.doBtst) begin
      statusOut[XBIT] = 1'b0;
      statusOut[NBIT] = btBit;
      statusOut[ZBIT] = btZero;
    end
    if (strobes.doBrev)  resultOut = brevVal;
    if (strobes.doBswap) resultOut = bswapVal;
    if (strobes.doHswap) resultOut = hswapVal;
    if (strobes.doDstep) resultOut = dstepVal;
    if (strobes.doBound) resultOut = boundVal;
    if (strobes.doLzc)   resultOut = DATA_W'(lzCount);
    if (strobes.doShl)   resultOut = shlVal;
    if (strobes.doShr)   resultOut = shrVal;
    if (strobes.doSar)   resultOut = sarVal;
    if (strobes.doMul) begin
      resultOut  = product[DATA_W-1:0];
      mulHighOut = product[2*DATA_W-1:DATA_W];
    end
  end

  always_comb begin
    // R1
    if (strobes.doBtst) btst_keep_dest_chk: assert (resultOut == aIn)
      else $error("bit test altered the destination");
    // R3
    stat_other_bits_chk: assert ((statusOut & ~FLAG_MASK) == (statusIn & ~FLAG_MASK))
      else $error("status bits outside the flag set changed");
    // R3
    if (strobes.doBtst) btst_x_clear_chk: assert (!statusOut[XBIT])
      else $error("bit test left X set");
    // R7
    if (strobes.doBound) bound_range_chk: assert (resultOut <= aIn && resultOut <= bIn)
      else $error("bound result above an operand");
    // R8
    if (strobes.doLzc) lzc_range_chk: assert (resultOut <= DATA_W'(DATA_W))
      else $error("leading zero count out of range");
    // R9
    if ((strobes.doShl || strobes.doShr) && bIn > SH_MAX) big_shift_zero_chk: assert (resultOut == '0)
      else $error("oversized logical shift not zero");
    // R10
    if (!strobes.doMul) mul_high_idle_chk: assert (mulHighOut == '0)
      else $error("upper word driven outside multiply");
  end
endmodule

// File: rtl/bmx_unit.sv
module bmx_unit
  import bmx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAT_W = 32
) (
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic [STAT_W-1:0] statusIn,
  output logic [DATA_W-1:0] resultOut,
  output logic [STAT_W-1:0] statusOut,
  output logic [DATA_W-1:0] mulHighOut
);
  bmx_strobe_t strobes;

  bmx_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  bmx_datapath #(
    .DATA_W (DATA_W),
    .STAT_W (STAT_W),
    .XBIT   (4),
    .NBIT   (3),
    .ZBIT   (2)
  ) u_dp (
    .strobes    (strobes),
    .aIn        (aIn),
    .bIn        (bIn),
    .statusIn   (statusIn),
    .resultOut  (resultOut),
    .statusOut  (statusOut),
    .mulHighOut (mulHighOut)
  );

  always_comb begin
    // R11
    if (opSel > OP_W'(OP_MULU)) spare_op_pass_chk: assert (resultOut == aIn && statusOut == statusIn && mulHighOut == '0)
      else $error("spare opcode did not pass A through");
  end
endmodule

// File: tb/sim_bmx_unit.sv
module sim_bmx_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [3:0]  opSel;
  logic [31:0] aIn, bIn, statusIn;
  logic [31:0] resultOut, statusOut, mulHighOut;

  bmx_unit u0 (
    .opSel(opSel), .aIn(aIn), .bIn(bIn), .statusIn(statusIn),
    .resultOut(resultOut), .statusOut(statusOut), .mulHighOut(mulHighOut)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] nextRand();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic expect32(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s op=%0d a=%h b=%h actual=%h expected=%h", tag, what, opSel, aIn, bIn, act, exp);
    end
  endtask

  // behavioural reference: result, status, upper word and requirement tag
  task automatic model(input int op, input logic [31:0] a, input logic [31:0] b, input logic [31:0] st,
                       output logic [31:0] r, output logic [31:0] s, output logic [31:0] h,
                       output string tag);
    longint sp;
    logic [63:0] up;
    int sel, cnt;
    logic zf;
    r = a; s = st; h = 0;
    case (op)
      0: begin // R1, R2, R3
        sel = int'(b % 32);
        zf = 1;
        for (int i = 0; i <= sel; i++) if (a[i]) zf = 0;
        s[4] = 0; s[3] = a[sel]; s[2] = zf;
        tag = "R1";
      end
      1: begin // R4
        for (int k = 0; k < 4; k++)
          for (int i = 0; i < 8; i++) r[8*k+i] = a[8*k+7-i];
        tag = "R4";
      end
      2: begin r = {a[23:16], a[31:24], a[7:0], a[15:8]}; tag = "R5"; end
      3: begin r = {a[15:0], a[31:16]}; tag = "R5"; end
      4: begin // R6
        r = a * 2;
        if (r >= b) r = r - b;
        tag = "R6";
      end
      5: begin r = (a > b) ? b : a; tag = "R7"; end
      6: begin // R8
        cnt = 0;
        for (int i = 31; i >= 0 && !b[i]; i--) cnt++;
        r = cnt; tag = "R8";
      end
      7, 8, 9: begin // R9
        r = a;
        if (b > 31) begin
          r = (op == 9 && a[31]) ? 32'hFFFF_FFFF : 0;
        end else begin
          for (int i = 0; i < int'(b); i++) begin
            if (op == 7) r = r * 2;
            else if (op == 8) r = r / 2;
            else r = {r[31], r[31:1]};
          end
        end
        tag = "R9";
      end
      10: begin // R10
        sp = longint'($signed(a)) * longint'($signed(b));
        r = sp[31:0]; h = sp[63:32]; tag = "R10";
      end
      11: begin
        up = {32'd0, a} * {32'd0, b};
        r = up[31:0]; h = up[63:32]; tag = "R10";
      end
      default: tag = "R11";
    endcase
  endtask

  task automatic runVector(input logic [31:0] a, input logic [31:0] b, input logic [31:0] st);
    logic [31:0] er, es, eh;
    string tag;
    for (int op = 0; op < 16; op++) begin
      @(posedge clk);
      #1;
      opSel = op[3:0]; aIn = a; bIn = b; statusIn = st;
      model(op, a, b, st, er, es, eh, tag);
      @(negedge clk);
      expect32(tag, "result", resultOut, er);
      // R2 status flags for bit test, R3 pass-through elsewhere, R11 for spares
      expect32(op == 0 ? "R2" : (op > 11 ? "R11" : "R3"), "status", statusOut, es);
      // R10 upper word
      expect32(op > 11 ? "R11" : "R10", "upper", mulHighOut, eh);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    opSel = 0; aIn = 0; bIn = 0; statusIn = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R8 all-zero operands: count 32, R2 Z set
    runVector(32'h0, 32'h0, 32'h0);
    // R2 selected bit and lower zero, upper set; junk above bit 4 of B
    runVector(32'hFFFF_FF00, 32'hABCD_0007, 32'hFFFF_FFFF);
    runVector(32'hFFFF_FF00, 32'h0000_0008, 32'h0000_0010);
    // R1 select bit 31
    runVector(32'h8000_0000, 32'h0000_001F, 32'h5A5A_5A5A);
    runVector(32'h7FFF_FFFF, 32'h0000_001F, 32'hA5A5_A5A5);
    // R9 counts at and above the limit, negative A
    runVector(32'h8000_0001, 32'h0000_0020, 32'h0);
    runVector(32'h8000_0001, 32'h8000_0000, 32'h0);
    runVector(32'h4000_0001, 32'h0000_0021, 32'h0);
    runVector(32'hF0F0_1234, 32'h0000_001F, 32'h0);
    // R6 shifted value equals B; R7 A equals B
    runVector(32'h0000_4000, 32'h0000_8000, 32'h0);
    runVector(32'h0000_8000, 32'h0000_8000, 32'h0);
    // R10 extremes
    runVector(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);
    runVector(32'h8000_0000, 32'h7FFF_FFFF, 32'h0);
    // R4 R5 patterns
    runVector(32'h0123_4567, 32'h89AB_CDEF, 32'h0000_001C);
    for (int n = 0; n < 60; n++) begin
      logic [31:0] ra, rb, rs;
      ra = nextRand();
      rb = nextRand();
      rs = nextRand();
      if (n % 2 == 0) rb = rb & 32'h3F;
      runVector(ra, rb, rs);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule